// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host write bus and a flash array controller. It turns a stream of bus writes into flash operations. Some operations take one bus write, some take two and one takes three. The first write of a sequence carries an opcode. A later write carries a program address and data, a confirm code, or a configuration value. The block also keeps the read-mode selection that tells the read path what to return: array contents, the device identifier, the status register, or the extended status registers.

Each completed operation appears as a one-cycle pulse together with an operation kind, the address it applies to and the data word. The block keeps two sticky error bits that mark a malformed sequence. It also keeps the configuration of the ready/busy output. The program and erase engine is outside the block. It reports back only through the `busy` input. While `busy` is high, the sequencer accepts only a small set of commands and the read path is steered to status.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `read_sel` is 0 (array), both error bits are 0, `rb_mode` is 1 (level) and `op_valid` is 0.
- R2: An opcode write changes the read mode, and the mode stays until another such write changes it. The opcodes and `read_sel` values are: 8'hFF gives 0 (array), 8'h90 gives 1 (identifier), 8'h70 gives 2 (status) and 8'h71 gives 3 (extended status).
- R3: Opcode 8'h40 or 8'h10, followed by a write, issues a program operation. The operation has kind 1, the address of the second write and data {8'h00, second data}.
- R4: Opcode 8'hFB starts a three-write sequence. The second write carries the low byte. The third write carries the high byte and the address. The sequence issues kind 2 with data {high, low}.
- R5: Four opcodes need a confirm write of 8'hD0, which issues the operation at the confirm write's address with data 0. The opcodes and kinds are: 8'h20 gives erase, kind 3; 8'h77 gives lock, kind 4; 8'h97 gives upload, kind 5; 8'hA7 gives erase-all-unlocked, kind 6.
- R6: If a confirm write does not carry 8'hD0, the sequencer issues no operation. It sets both `seq_err` and `op_err` and sets the read mode to 2 (status).
- R7: The error bits stay set until opcode 8'h50 clears them both.
- R8: Opcode 8'h96 followed by data 1 to 5 loads that value into `rb_mode`. The values mean: 1 level, 2 pulse on program, 3 pulse on erase, 4 off, 5 pulse on both. Any other data leaves `rb_mode` unchanged and is handled as a bad confirm (R6).
- R9: Opcode 8'hB0 while `busy` issues kind 7 (suspend). The next 8'hD0 opcode then issues kind 8 (resume). 8'hB0 has no effect when `busy` is low. 8'hD0 with no suspend pending is handled as unrecognised (R12).
- R10: Opcode 8'hF0 issues kind 9 (sleep) and 8'h80 issues kind 10 (abort). Each is a single write, and both are accepted while `busy`.
- R11: While `busy`, every write other than 8'hB0, 8'h70, 8'hF0 and 8'h80 has no effect on operations, errors, read mode or sequence state. While `busy`, `read_sel` shows 2.
- R12: An unrecognised first-cycle opcode issues no operation and sets the read mode to 0.
- R13: `op_valid` rises in the cycle after the write that completes a sequence and stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / opcode |
| busy | input | 1 | Program/erase engine busy |
| op_valid | output | 1 | Operation issue pulse |
| op_kind | output | 4 | Operation kind code |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | 16 | Operation data word |
| read_sel | output | 2 | Read path selection |
| seq_err | output | 1 | Sticky sequence error |
| op_err | output | 1 | Sticky program/erase error |
| rb_mode | output | 3 | Ready/busy output configuration |

## Verification
The hardest situation to reach is a sequence that meets `busy`. To show that a write was ignored while `busy` was high, the bench must look at what happens afterwards. It first leaves an error set, then raises `busy` and sends the clear opcode and an erase setup opcode. It then drops `busy` and sends the clear opcode once more. The errors clear only if the erase setup really was dropped. Had it been accepted, that last write would have become a bad confirm. The suspend-then-resume pair is handled the same way: `busy` is toggled between the two writes.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_STATUS = 2'd2,
        RD_XSTAT  = 2'd3
    } rd_sel_e;

    typedef enum logic [3:0] {
        OP_NONE      = 4'd0,
        OP_PROG      = 4'd1,
        OP_PROG2     = 4'd2,
        OP_ERASE     = 4'd3,
        OP_LOCK      = 4'd4,
        OP_UPLOAD    = 4'd5,
        OP_ERASE_ALL = 4'd6,
        OP_SUSPEND   = 4'd7,
        OP_RESUME    = 4'd8,
        OP_SLEEP     = 4'd9,
        OP_ABORT     = 4'd10
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WDATA,
        ST_CONFIRM,
        ST_RBCFG,
        ST_LO,
        ST_HI
    } seq_st_e;

    localparam logic [2:0] RB_LEVEL = 3'd1;

    localparam logic [CMD_W-1:0] OPC_RD_ARRAY  = 8'hFF;
    localparam logic [CMD_W-1:0] OPC_RD_IDENT  = 8'h90;
    localparam logic [CMD_W-1:0] OPC_RD_STAT   = 8'h70;
    localparam logic [CMD_W-1:0] OPC_RD_XSTAT  = 8'h71;
    localparam logic [CMD_W-1:0] OPC_CLR_ERR   = 8'h50;
    localparam logic [CMD_W-1:0] OPC_PROG_A    = 8'h40;
    localparam logic [CMD_W-1:0] OPC_PROG_B    = 8'h10;
    localparam logic [CMD_W-1:0] OPC_ERASE     = 8'h20;
    localparam logic [CMD_W-1:0] OPC_LOCK      = 8'h77;
    localparam logic [CMD_W-1:0] OPC_UPLOAD    = 8'h97;
    localparam logic [CMD_W-1:0] OPC_ERASE_ALL = 8'hA7;
    localparam logic [CMD_W-1:0] OPC_SUSPEND   = 8'hB0;
    localparam logic [CMD_W-1:0] OPC_CONFIRM   = 8'hD0;
    localparam logic [CMD_W-1:0] OPC_RB_CFG    = 8'h96;
    localparam logic [CMD_W-1:0] OPC_SLEEP     = 8'hF0;
    localparam logic [CMD_W-1:0] OPC_ABORT     = 8'h80;
    localparam logic [CMD_W-1:0] OPC_TWO_BYTE  = 8'hFB;

    function automatic logic busy_ok(input logic [CMD_W-1:0] c);
        return (c == OPC_SUSPEND) || (c == OPC_RD_STAT) ||
               (c == OPC_SLEEP)   || (c == OPC_ABORT);
    endfunction

    function automatic op_kind_e confirm_kind(input logic [CMD_W-1:0] c);
        case (c)
            OPC_ERASE:     return OP_ERASE;
            OPC_LOCK:      return OP_LOCK;
            OPC_UPLOAD:    return OP_UPLOAD;
            OPC_ERASE_ALL: return OP_ERASE_ALL;
            default:       return OP_NONE;
        endcase
    endfunction

    function automatic logic rb_legal(input logic [CMD_W-1:0] c);
        return (c >= 8'd1) && (c <= 8'd5);
    endfunction

endpackage

// File: rtl/fcs_status.sv
module fcs_status (
    input  logic clk,
    input  logic rst,
    input  logic err_set,
    input  logic err_clr,
    output logic seq_err,
    output logic op_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            seq_err <= 1'b0;
            op_err  <= 1'b0;
        end else if (err_set) begin
            seq_err <= 1'b1;
            op_err  <= 1'b1;
        end else if (err_clr) begin
            seq_err <= 1'b0;
            op_err  <= 1'b0;
        end
    end

    // R7: error bits stay until the clear opcode
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (seq_err && !err_clr) |=> seq_err);
    p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !err_set) |=> (!seq_err && !op_err));
endmodule

// File: rtl/fcs_rb_cfg.sv
module fcs_rb_cfg
    import fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rb_wr,
    input  logic [2:0] rb_val,
    output logic [2:0] rb_mode
);
    always_ff @(posedge clk) begin
        if (rst)        rb_mode <= RB_LEVEL;
        else if (rb_wr) rb_mode <= rb_val;
    end

    // R8: mode is always one of the five legal settings
    p_rb_legal_r8: assert property (@(posedge clk) disable iff (rst)
        (rb_mode >= 3'd1) && (rb_mode <= 3'd5));
    p_rb_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rb_wr |=> $stable(rb_mode));
endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CMD_W-1:0]     wr_data,
    input  logic                 busy,
    output logic                 op_valid,
    output op_kind_e             op_kind,
    output logic [ADDR_W-1:0]    op_addr,
    output logic [2*CMD_W-1:0]   op_data,
    output rd_sel_e              rd_mode,
    output logic                 err_set,
    output logic                 err_clr,
    output logic                 rb_wr,
    output logic [2:0]           rb_val
);
    seq_st_e            st_q, st_n;
    op_kind_e           pend_q, pend_n;
    logic [CMD_W-1:0]   lo_q, lo_n;
    logic               susp_q, susp_n;
    rd_sel_e            rd_n;
    logic               go;
    op_kind_e           kind_n;
    logic [2*CMD_W-1:0] data_n;
    logic               accept;

    assign accept = wr_en && (!busy || (st_q == ST_IDLE && busy_ok(wr_data)));
    assign rb_val = wr_data[2:0];

    always_comb begin
        st_n    = st_q;
        pend_n  = pend_q;
        lo_n    = lo_q;
        susp_n  = susp_q;
        rd_n    = rd_mode;
        go      = 1'b0;
        kind_n  = OP_NONE;
        data_n  = '0;
        err_set = 1'b0;
        err_clr = 1'b0;
        rb_wr   = 1'b0;
        if (accept) begin
            case (st_q)
                ST_IDLE: begin
                    case (wr_data)
                        OPC_RD_ARRAY: rd_n = RD_ARRAY;
                        OPC_RD_IDENT: rd_n = RD_IDENT;
                        OPC_RD_STAT:  rd_n = RD_STATUS;
                        OPC_RD_XSTAT: rd_n = RD_XSTAT;
                        OPC_CLR_ERR:  err_clr = 1'b1;
                        OPC_PROG_A, OPC_PROG_B: st_n = ST_WDATA;
                        OPC_ERASE, OPC_LOCK, OPC_UPLOAD, OPC_ERASE_ALL: begin
                            st_n   = ST_CONFIRM;
                            pend_n = confirm_kind(wr_data);
                        end
                        OPC_RB_CFG:   st_n = ST_RBCFG;
                        OPC_TWO_BYTE: st_n = ST_LO;
                        OPC_SUSPEND: begin
                            if (busy) begin
                                go     = 1'b1;
                                kind_n = OP_SUSPEND;
                                susp_n = 1'b1;
                            end
                        end
                        OPC_CONFIRM: begin
                            if (susp_q) begin
                                go     = 1'b1;
                                kind_n = OP_RESUME;
                                susp_n = 1'b0;
                            end else begin
                                rd_n = RD_ARRAY;
                            end
                        end
                        OPC_SLEEP: begin
                            go     = 1'b1;
                            kind_n = OP_SLEEP;
                        end
                        OPC_ABORT: begin
                            go     = 1'b1;
                            kind_n = OP_ABORT;
                            susp_n = 1'b0;
                        end
                        default: rd_n = RD_ARRAY;
                    endcase
                end
                ST_WDATA: begin
                    go     = 1'b1;
                    kind_n = OP_PROG;
                    data_n = {{CMD_W{1'b0}}, wr_data};
                    st_n   = ST_IDLE;
                end
                ST_CONFIRM: begin
                    if (wr_data == OPC_CONFIRM) begin
                        go     = 1'b1;
                        kind_n = pend_q;
                    end else begin
                        err_set = 1'b1;
                        rd_n    = RD_STATUS;
                    end
                    st_n = ST_IDLE;
                end
                ST_RBCFG: begin
                    if (rb_legal(wr_data)) begin
                        rb_wr = 1'b1;
                    end else begin
                        err_set = 1'b1;
                        rd_n    = RD_STATUS;
                    end
                    st_n = ST_IDLE;
                end
                ST_LO: begin
                    lo_n = wr_data;
                    st_n = ST_HI;
                end
                ST_HI: begin
                    go     = 1'b1;
                    kind_n = OP_PROG2;
                    data_n = {wr_data, lo_q};
                    st_n   = ST_IDLE;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            pend_q   <= OP_NONE;
            lo_q     <= '0;
            susp_q   <= 1'b0;
            rd_mode  <= RD_ARRAY;
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            st_q     <= st_n;
            pend_q   <= pend_n;
            lo_q     <= lo_n;
            susp_q   <= susp_n;
            rd_mode  <= rd_n;
            op_valid <= go;
            if (go) begin
                op_kind <= kind_n;
                op_addr <= wr_addr;
                op_data <= data_n;
            end
        end
    end

    // R13: an issued operation always follows a bus write
    p_op_after_write_r13: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> $past(wr_en));
    // R11: disallowed writes while busy never issue an operation
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !busy_ok(wr_data)) |=> !op_valid);
    // R6: a bad confirm issues nothing and steers reads to status
    p_bad_confirm_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONFIRM && wr_en && !busy && wr_data != OPC_CONFIRM)
        |=> (!op_valid && rd_mode == RD_STATUS));
    // R10: sleep acts in one write
    p_sleep_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && wr_en && wr_data == OPC_SLEEP)
        |=> (op_valid && op_kind == OP_SLEEP));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic [1:0]        read_sel,
    output logic              seq_err,
    output logic              op_err,
    output logic [2:0]        rb_mode
);
    op_kind_e   kind_w;
    rd_sel_e    rd_mode_w;
    logic       err_set_w, err_clr_w, rb_wr_w;
    logic [2:0] rb_val_w;

    fcs_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (busy),
        .op_valid (op_valid),
        .op_kind  (kind_w),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .rd_mode  (rd_mode_w),
        .err_set  (err_set_w),
        .err_clr  (err_clr_w),
        .rb_wr    (rb_wr_w),
        .rb_val   (rb_val_w)
    );

    fcs_status u_status (
        .clk     (clk),
        .rst     (rst),
        .err_set (err_set_w),
        .err_clr (err_clr_w),
        .seq_err (seq_err),
        .op_err  (op_err)
    );

    fcs_rb_cfg u_rb (
        .clk     (clk),
        .rst     (rst),
        .rb_wr   (rb_wr_w),
        .rb_val  (rb_val_w),
        .rb_mode (rb_mode)
    );

    assign op_kind  = kind_w;
    assign read_sel = busy ? RD_STATUS : rd_mode_w;

    // R6: the sequencer's error request lands in both sticky bits
    p_err_lands_r6: assert property (@(posedge clk) disable iff (rst)
        err_set_w |=> (seq_err && op_err));
endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy = 1'b0;
    logic          op_valid;
    logic [3:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;
    logic [1:0]    read_sel;
    logic          seq_err, op_err;
    logic [2:0]    rb_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [35:0] expq[$];

    always #10 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .op_valid(op_valid),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .read_sel(read_sel), .seq_err(seq_err), .op_err(op_err),
        .rb_mode(rb_mode)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_op(input logic [3:0] k, input logic [AW-1:0] a, input logic [15:0] d);
        expq.push_back({k, a, d});
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: every issued operation is compared to the next expected one (R3 R4 R5 R9 R10 R13)
    always @(negedge clk) begin
        if (!rst && op_valid) begin
            if (expq.size() == 0) begin
                chk("R13 unexpected op", {op_kind, op_addr, op_data}, 36'h0);
            end else begin
                logic [35:0] e;
                e = expq.pop_front();
                chk("op scoreboard", {op_kind, op_addr, op_data}, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 read_sel", read_sel, 0);
        chk("R1 seq_err", seq_err, 0);
        chk("R1 op_err", op_err, 0);
        chk("R1 rb_mode", rb_mode, 1);
        chk("R1 op_valid", op_valid, 0);

        // R2
        wr(0, 8'h90); chk("R2 ident", read_sel, 1);
        wr(0, 8'h70); chk("R2 status", read_sel, 2);
        wr(0, 8'h71); chk("R2 xstatus", read_sel, 3);
        idle(5);      chk("R2 persists", read_sel, 3);
        wr(0, 8'hFF); chk("R2 array", read_sel, 0);

        // R3 and R13
        expect_op(4'd1, 16'h1234, 16'h00AB);
        wr(0, 8'h40); wr(16'h1234, 8'hAB);
        @(negedge clk); chk("R13 single pulse", op_valid, 0);
        expect_op(4'd1, 16'h0F0F, 16'h0033);
        wr(0, 8'h10); wr(16'h0F0F, 8'h33);

        // R4
        expect_op(4'd2, 16'h2000, 16'h9C3E);
        wr(0, 8'hFB); wr(16'h0005, 8'h3E); wr(16'h2000, 8'h9C);

        // R5
        expect_op(4'd3, 16'h4000, 16'h0000);
        wr(0, 8'h20); wr(16'h4000, 8'hD0);
        expect_op(4'd4, 16'h5000, 16'h0000);
        wr(0, 8'h77); wr(16'h5000, 8'hD0);
        expect_op(4'd5, 16'h0001, 16'h0000);
        wr(0, 8'h97); wr(16'h0001, 8'hD0);
        expect_op(4'd6, 16'h0002, 16'h0000);
        wr(0, 8'hA7); wr(16'h0002, 8'hD0);

        // R6 and R7
        wr(0, 8'h20); wr(16'h4000, 8'hFF);
        chk("R6 seq_err", seq_err, 1);
        chk("R6 op_err", op_err, 1);
        chk("R6 read status", read_sel, 2);
        idle(4);
        chk("R7 sticky", seq_err, 1);
        wr(0, 8'h50);
        chk("R7 cleared seq", seq_err, 0);
        chk("R7 cleared op", op_err, 0);

        // R8
        wr(0, 8'h96); wr(0, 8'h03); chk("R8 rb pulse-erase", rb_mode, 3);
        wr(0, 8'h96); wr(0, 8'h07);
        chk("R8 bad value kept", rb_mode, 3);
        chk("R8 bad value error", seq_err, 1);
        wr(0, 8'h50);
        wr(0, 8'h96); wr(0, 8'h05); chk("R8 rb both", rb_mode, 5);
        chk("R8 no error", seq_err, 0);

        // R11: errors set, then busy ignores clear and setup
        wr(0, 8'h77); wr(0, 8'h00);
        busy = 1'b1;
        @(negedge clk); chk("R11 read forced status", read_sel, 2);
        wr(0, 8'h50); chk("R11 clear ignored", seq_err, 1);
        wr(0, 8'h20);
        wr(0, 8'h90); chk("R11 busy read_sel", read_sel, 2);
        busy = 1'b0;
        @(negedge clk); chk("R11 mode untouched", read_sel, 2);
        wr(0, 8'h50); chk("R11 setup was dropped", seq_err, 0);

        // R10
        busy = 1'b1;
        expect_op(4'd9, 16'h0011, 16'h0000); wr(16'h0011, 8'hF0);
        expect_op(4'd10, 16'h0022, 16'h0000); wr(16'h0022, 8'h80);
        busy = 1'b0;

        // R9
        wr(0, 8'hB0); idle(2);
        busy = 1'b1;
        expect_op(4'd7, 16'h0033, 16'h0000); wr(16'h0033, 8'hB0);
        busy = 1'b0;
        wr(0, 8'h90);
        expect_op(4'd8, 16'h0044, 16'h0000); wr(16'h0044, 8'hD0);
        chk("R9 resume keeps mode", read_sel, 1);
        wr(0, 8'hD0); chk("R9 stray confirm", read_sel, 0);

        // R12
        wr(0, 8'h90);
        wr(0, 8'h33); chk("R12 unknown to array", read_sel, 0);
        chk("R12 no error", seq_err, 0);

        idle(4);
        chk("R13 all expected ops seen", expq.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule